// File: doc/BRIEF.md
# GPIO and Alert Pin Controller

This block drives three open-drain general-purpose pins and reads them back. Each pin can be set up as an input, with a programmable active level, or as an output that can only pull the pad low or release it to high impedance. The third pin has one more use: it can serve as the shared alert line. In that role it pulls low while the system alert aggregator reports a pending event, or while a sticky force bit is set.

The block takes the analog comparator result for each pad. Each result passes through a two-flop synchronizer. After that it is reported as a status bit and compared with the programmed active level. An active input can raise a GPIO alert request toward the alert aggregator. Pin 2 can also gate the time, charge and energy accumulators.

The pin-3 control register holds two bits, force and drive, and is loaded by a write strobe. Hardware sets the force bit on every cycle in which an alert event is present, whatever pin 3 is configured as. There is no streaming data path: all ports are plain control and status levels.

Top module: `gpio_alert_ctrl`

## Requirements
- R1: `cmp_status[i]` reports the comparator result of pin i+1 (index 0 = pin 1, 1 = pin 2, 2 = pin 3) after two clock edges of synchronization. It reads 0 after reset.
- R2: A pin is active when its synchronized comparator value equals its `act_high` bit: 1 means active when above threshold, 0 means active when below.
- R3: `gpio_alert_req[0]` is high when pin 1 is an input (`pin_out_mode[0]`=0), active and `gpio_alert_en[0]`=1. `gpio_alert_req[1]` behaves the same way for pin 2 with bit 1 of each field. Both are low otherwise.
- R4: `acc_enable` equals the pin-2 active state when `acc_src_sel` is 2'b10. For any other value it is 1.
- R5: Pins 1 and 2 in output mode (`pin_out_mode` bit = 1) pull low exactly when their `out_pull` bit is 1. In input mode they never pull low.
- R6: With `p3_mode`=2'b00 (alert), pin 3 pulls low when `alert_event` is high or `p3_force` is 1. It is released only when both are clear.
- R7: With `p3_mode`=2'b10 or 2'b11 (output), pin 3 pulls low exactly when `p3_drive` is 1, and the force bit has no effect. With `p3_mode`=2'b01 (input), pin 3 never pulls low.
- R8: Any cycle with `alert_event` high sets `p3_force` at the next edge, in every pin-3 mode. If a software write arrives in the same cycle, hardware wins.
- R9: A cycle with `p3_wr` high loads `p3_wr_drive` into `p3_drive` at the next edge. It also loads `p3_wr_force` into `p3_force`, unless R8 applies. Alert events never change `p3_drive`. Both bits reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | 3 | Raw comparator results, pin 1 at bit 0 |
| pin_out_mode | input | 2 | Pins 1 and 2: 0 input, 1 output |
| p3_mode | input | 2 | Pin 3: 00 alert, 01 input, 1x output |
| act_high | input | 3 | Active level per pin, 1 = high |
| out_pull | input | 2 | Pull-low request for pins 1 and 2 |
| gpio_alert_en | input | 2 | Alert enable for pins 1 and 2 |
| acc_src_sel | input | 2 | Accumulator source select, 10 = pin 2 |
| alert_event | input | 1 | Aggregated pending alert |
| p3_wr | input | 1 | Pin-3 control register write strobe |
| p3_wr_force | input | 1 | Write data for the force bit |
| p3_wr_drive | input | 1 | Write data for the drive bit |
| pin_pull_low | output | 3 | Open-drain pull-low enables, pin 1 at bit 0 |
| cmp_status | output | 3 | Synchronized comparator status |
| gpio_alert_req | output | 2 | Alert requests from pins 1 and 2 |
| acc_enable | output | 1 | Accumulator enable |
| p3_force | output | 1 | Force bit readback |
| p3_drive | output | 1 | Drive bit readback |

## Verification
Two things can happen in the same cycle: hardware setting the force bit on an alert event, and a software write that clears it. The bench creates this collision on purpose, with an alert event and a `p3_wr` carrying force=0 on one edge. The next cycle must show the force bit set and the drive bit loaded from the write. The random phase keeps producing this overlap in every pin-3 mode, and a cycle model checks every output after each edge.

// File: rtl/gpio_alert_pkg.sv
package gpio_alert_pkg;
  typedef enum logic [1:0] {
    P3_ALERT   = 2'b00,
    P3_INPUT   = 2'b01,
    P3_OUT     = 2'b10,
    P3_OUT_ALT = 2'b11
  } p3_mode_e;

  function automatic logic p3_is_output(input p3_mode_e m);
    return (m == P3_OUT) || (m == P3_OUT_ALT);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[LAST];
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
  parameter int NPINS  = 3,
  parameter int NALERT = 2
) (
  input  logic [NPINS-1:0]  sync_val,
  input  logic [NPINS-1:0]  act_high,
  input  logic [NALERT-1:0] is_input,
  input  logic [NALERT-1:0] alert_en,
  output logic [NPINS-1:0]  pin_active,
  output logic [NALERT-1:0] alert_req
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pol
    assign pin_active[i] = ~(sync_val[i] ^ act_high[i]);
  end

  for (genvar j = 0; j < NALERT; j++) begin : g_req
    assign alert_req[j] = is_input[j] & alert_en[j] & pin_active[j];
  end
endmodule

// File: rtl/gpio3_ctrl_reg.sv
module gpio3_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic wr,
  input  logic wr_force,
  input  logic wr_drive,
  output logic force_q,
  output logic drive_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      force_q <= 1'b0;
    else if (hw_set) force_q <= 1'b1;
    else if (wr)     force_q <= wr_force;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  drive_q <= 1'b0;
    else if (wr) drive_q <= wr_drive;
  end

  // R8: hardware set takes priority over any same-cycle write
  a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> force_q);
  // R9: write loads force when no alert collides
  a_r9_force_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hw_set) |=> (force_q == $past(wr_force)));
  // R9: drive follows writes only
  a_r9_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(drive_q));
endmodule

// File: rtl/gpio_alert_ctrl.sv
module gpio_alert_ctrl
  import gpio_alert_pkg::*;
#(
  parameter int NPINS       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmp_above,
  input  logic [1:0] pin_out_mode,
  input  logic [1:0] p3_mode,
  input  logic [2:0] act_high,
  input  logic [1:0] out_pull,
  input  logic [1:0] gpio_alert_en,
  input  logic [1:0] acc_src_sel,
  input  logic       alert_event,
  input  logic       p3_wr,
  input  logic       p3_wr_force,
  input  logic       p3_wr_drive,
  output logic [2:0] pin_pull_low,
  output logic [2:0] cmp_status,
  output logic [1:0] gpio_alert_req,
  output logic       acc_enable,
  output logic       p3_force,
  output logic       p3_drive
);
  localparam int NGP   = NPINS - 1;
  localparam int P3    = NPINS - 1;
  localparam int P2    = 1;
  localparam logic [1:0] ACC_FROM_PIN2 = 2'b10;

  logic [NPINS-1:0] sync_val;
  logic [NPINS-1:0] pin_active;
  p3_mode_e         mode3;

  assign mode3 = p3_mode_e'(p3_mode);

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_above),
    .q_sync  (sync_val)
  );

  gpio_in_path #(.NPINS(NPINS), .NALERT(NGP)) u_path (
    .sync_val   (sync_val),
    .act_high   (act_high),
    .is_input   (~pin_out_mode),
    .alert_en   (gpio_alert_en),
    .pin_active (pin_active),
    .alert_req  (gpio_alert_req)
  );

  gpio3_ctrl_reg u_p3reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set   (alert_event),
    .wr       (p3_wr),
    .wr_force (p3_wr_force),
    .wr_drive (p3_wr_drive),
    .force_q  (p3_force),
    .drive_q  (p3_drive)
  );

  assign cmp_status = sync_val;
  assign acc_enable = (acc_src_sel == ACC_FROM_PIN2) ? pin_active[P2] : 1'b1;

  for (genvar i = 0; i < NGP; i++) begin : g_gp_out
    assign pin_pull_low[i] = pin_out_mode[i] & out_pull[i];
  end

  always_comb begin
    unique case (mode3)
      P3_ALERT:          pin_pull_low[P3] = alert_event | p3_force;
      P3_INPUT:          pin_pull_low[P3] = 1'b0;
      P3_OUT, P3_OUT_ALT: pin_pull_low[P3] = p3_drive;
      default:           pin_pull_low[P3] = 1'b0;
    endcase
  end

  // R5: input-mode pins stay released
  a_r5_pin1_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_out_mode[0] |-> !pin_pull_low[0]);
  a_r5_pin2_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_out_mode[1] |-> !pin_pull_low[1]);
  // R3: alert requests only from input-mode pins
  a_r3_req_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_alert_req & pin_out_mode) == 2'b00);
  // R6: a past alert keeps the alert line low through the force bit
  a_r6_alert_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(alert_event) && mode3 == P3_ALERT) |-> pin_pull_low[P3]);
  // R7: pin 3 in input mode never pulls low
  a_r7_p3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode3 == P3_INPUT) |-> !pin_pull_low[P3]);
  // R4: accumulators free-running unless pin 2 is selected
  a_r4_acc_default_on: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_src_sel != ACC_FROM_PIN2) |-> acc_enable);
endmodule

// File: tb/gpio_alert_ctrl_bench.sv
module gpio_alert_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmp_above = '0;
  logic [1:0] pin_out_mode = '0;
  logic [1:0] p3_mode = '0;
  logic [2:0] act_high = '0;
  logic [1:0] out_pull = '0;
  logic [1:0] gpio_alert_en = '0;
  logic [1:0] acc_src_sel = '0;
  logic       alert_event = 1'b0;
  logic       p3_wr = 1'b0;
  logic       p3_wr_force = 1'b0;
  logic       p3_wr_drive = 1'b0;
  logic [2:0] pin_pull_low;
  logic [2:0] cmp_status;
  logic [1:0] gpio_alert_req;
  logic       acc_enable;
  logic       p3_force;
  logic       p3_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alert_ctrl u_gpio_alert_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_above(cmp_above), .pin_out_mode(pin_out_mode),
    .p3_mode(p3_mode), .act_high(act_high), .out_pull(out_pull),
    .gpio_alert_en(gpio_alert_en), .acc_src_sel(acc_src_sel),
    .alert_event(alert_event), .p3_wr(p3_wr), .p3_wr_force(p3_wr_force),
    .p3_wr_drive(p3_wr_drive), .pin_pull_low(pin_pull_low),
    .cmp_status(cmp_status), .gpio_alert_req(gpio_alert_req),
    .acc_enable(acc_enable), .p3_force(p3_force), .p3_drive(p3_drive)
  );

  // model state built from the requirements
  logic [2:0] m_s1, m_s2;
  logic       m_force, m_drive;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_force <= 1'b0; m_drive <= 1'b0;
    end else begin
      m_s1 <= cmp_above;
      m_s2 <= m_s1;
      if (alert_event) m_force <= 1'b1;
      else if (p3_wr)  m_force <= p3_wr_force;
      if (p3_wr) m_drive <= p3_wr_drive;
    end
  end

  function automatic logic [2:0] f_active(input logic [2:0] s, input logic [2:0] pol);
    return ~(s ^ pol);
  endfunction

  function automatic logic [1:0] f_req(input logic [2:0] s, input logic [2:0] pol,
                                       input logic [1:0] om, input logic [1:0] en);
    logic [2:0] a;
    a = f_active(s, pol);
    return a[1:0] & ~om & en;
  endfunction

  function automatic logic f_acc(input logic [2:0] s, input logic [2:0] pol, input logic [1:0] sel);
    logic [2:0] a;
    a = f_active(s, pol);
    return (sel == 2'b10) ? a[1] : 1'b1;
  endfunction

  function automatic logic [2:0] f_pull(input logic [1:0] om, input logic [1:0] op,
                                        input logic [1:0] m3, input logic ev,
                                        input logic frc, input logic drv);
    logic p3;
    case (m3)
      2'b00:   p3 = ev | frc;
      2'b01:   p3 = 1'b0;
      default: p3 = drv;
    endcase
    return {p3, om & op};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 status", cmp_status, m_s2);
    chk("R2/R3 alert_req", {1'b0, gpio_alert_req},
        {1'b0, f_req(m_s2, act_high, pin_out_mode, gpio_alert_en)});
    chk("R4 acc_enable", {2'b0, acc_enable}, {2'b0, f_acc(m_s2, act_high, acc_src_sel)});
    chk("R5/R6/R7 pull_low", pin_pull_low,
        f_pull(pin_out_mode, out_pull, p3_mode, alert_event, m_force, m_drive));
    chk("R8/R9 force", {2'b0, p3_force}, {2'b0, m_force});
    chk("R9 drive", {2'b0, p3_drive}, {2'b0, m_drive});
  endtask

  // advance one edge, then check away from it
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic clear_wr();
    p3_wr = 1'b0; alert_event = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    acc_src_sel = 2'b00;
    repeat (2) @(negedge clk);
    // reset state: outputs zero, accumulators enabled (R1, R4, R9)
    chk("R1 reset status", cmp_status, 3'b000);
    chk("R9 reset force/drive", {1'b0, p3_force, p3_drive}, 3'b000);
    chk("R4 reset acc", {2'b0, acc_enable}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: two-edge synchronizer latency
    cmp_above = 3'b101;
    @(posedge clk); @(negedge clk);
    chk("R1 one edge not yet", cmp_status, 3'b000);
    @(posedge clk); @(negedge clk);
    chk("R1 after two edges", cmp_status, 3'b101);

    // R2/R3: active-low polarity on pin 1 below threshold raises request
    pin_out_mode = 2'b00; gpio_alert_en = 2'b11; act_high = 3'b010;
    cmp_above = 3'b010;
    step(); step();
    chk("R3 both pins active", {1'b0, gpio_alert_req}, 3'b011);

    // R4: pin 2 gates accumulators
    acc_src_sel = 2'b10; act_high = 3'b000; cmp_above = 3'b010;
    step(); step();
    chk("R4 pin2 inactive gates off", {2'b0, acc_enable}, 3'b000);

    // R8/R9: alert and software clear collide; hardware wins
    p3_mode = 2'b00;
    alert_event = 1'b1; p3_wr = 1'b1; p3_wr_force = 1'b0; p3_wr_drive = 1'b1;
    step();
    clear_wr();
    @(negedge clk);
    chk("R8 collision force set", {2'b0, p3_force}, 3'b001);
    chk("R9 collision drive loaded", {2'b0, p3_drive}, 3'b001);
    chk("R6 held low by force", {2'b0, pin_pull_low[2]}, 3'b001);

    // R7: output mode ignores force, follows drive
    p3_mode = 2'b10;
    p3_wr = 1'b1; p3_wr_force = 1'b1; p3_wr_drive = 1'b0;
    step(); clear_wr(); @(negedge clk);
    chk("R7 output mode drive 0 released", {2'b0, pin_pull_low[2]}, 3'b000);

    // R8: alert in input mode still sets force
    p3_mode = 2'b01; p3_wr = 1'b1; p3_wr_force = 1'b0;
    step(); clear_wr();
    alert_event = 1'b1;
    step(); clear_wr(); @(negedge clk);
    chk("R8 set in input mode", {2'b0, p3_force}, 3'b001);
    chk("R7 input mode released", {2'b0, pin_pull_low[2]}, 3'b000);

    // R6: clear force in alert mode, release only when both clear
    p3_mode = 2'b00; p3_wr = 1'b1; p3_wr_force = 1'b0;
    step(); clear_wr(); @(negedge clk);
    chk("R6 released both clear", {2'b0, pin_pull_low[2]}, 3'b000);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      cmp_above     = 3'($urandom);
      pin_out_mode  = 2'($urandom);
      p3_mode       = 2'($urandom);
      act_high      = 3'($urandom);
      out_pull      = 2'($urandom);
      gpio_alert_en = 2'($urandom);
      acc_src_sel   = 2'($urandom);
      alert_event   = ($urandom % 5) == 0;
      p3_wr         = ($urandom % 3) == 0;
      p3_wr_force   = 1'($urandom);
      p3_wr_drive   = 1'($urandom);
      step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule